// File: doc/BRIEF.md
# Two-Stage Prescaled Clock Generator

This block derives one output clock from four reference clocks, under the control of a single 32-bit control word. A two-bit parent field picks the reference. A two-bit prescale field divides that reference by 1, 2, 4 or 8. A five-bit divide field then divides the result by any value from 1 to 32. The output period is therefore `(divide + 1) << prescale` cycles of the chosen reference. Software writes the word through a byte-enabled write port and can read the word back at any time.

The reference is chosen by a break-before-make selector. Each reference has its own two-flop enable chain, so at most one reference ever reaches the internal clock. The divider runs on that internal clock as a small phase machine with three states:
- **PASS** forwards the reference unchanged. It is used when the total division is 1.
- **HIGH** and **LOW** drive the output high or low for the two halves of each divided period.

The transitions are as follows:
- **HIGH→LOW** fires when the position within the period reaches half the total.
- **LOW→HIGH**, **HIGH→HIGH** and **PASS→HIGH** fire at a period end when the next total is above 1.
- **any→PASS** fires at a period end when the next total is 1.

New settings are handed to the internal clock through a toggle handshake. They are loaded only at a period end, which is an output rising edge.

Top module: `prediv_clkgen`

## Requirements
- R1: After reset the control word reads 0, reference 0 is selected and the output follows reference 0 with its own period and duty cycle.
- R2: Bits 17:16 of the control word select the reference, where value k selects `ref_clk[k]`; the output period scales with the chosen reference.
- R3: Bits 5:4 (prescale p) divide the chosen reference by 2^p.
- R4: Bits 12:8 (divide n) further divide by n+1, so the output period is ((n+1)<<p) reference cycles, from 1 up to 256.
- R5: Byte enable 0 writes only the prescale field, enable 1 only the divide field and enable 2 only the parent field; a field whose lane is not enabled keeps its value.
- R6: A parent-lane write with any of data bits 23:18 set encodes an index of 4 or more; it is rejected and the parent field keeps its old value, while the other enabled lanes are still written.
- R7: All bits outside 17:16, 12:8 and 5:4 read as zero whatever is written.
- R8: For a total division D of 2 or more, the output is high for floor(D/2) reference cycles and low for the rest: equal halves when D is even, and a high phase one cycle shorter when D is odd. For D = 1 the reference passes through.
- R9: Changing any field never produces an output high or low pulse shorter than half a period of the fastest reference; new settings start at an output rising edge.
- R10: At most one reference is gated onto the internal clock at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| ref_clk | input | 4 | Reference clocks, index equals parent value |
| clk_out | output | 1 | Divided output clock |

## Verification
The hardest situation to reach is a reconfiguration that lands while a long divided period is still under way, sometimes together with a parent switch. The stimulus therefore writes random parent, prescale and divide values back to back, so most writes arrive in the middle of a period. Periods of up to 256 cycles are stretched onto the slowest reference. A monitor times every high and low pulse of the output against the narrowest legal width across all of these transitions. Directed cases add the division-by-one pass-through, the largest division, odd divisions, single-lane writes and rejected parent indexes.

// File: rtl/prediv_pkg.sv
package prediv_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW_W     = 32;
    localparam int NUM_REF  = 4;
    localparam int PAR_W    = 2;
    localparam int PSC_W    = 2;
    localparam int DVF_W    = 5;
    localparam int PAR_LSB  = 16;
    localparam int PSC_LSB  = 4;
    localparam int DVF_LSB  = 8;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/prediv_regs.sv
module prediv_regs #(
    parameter int CW_W    = 32,
    parameter int PAR_W   = 2,
    parameter int PSC_W   = 2,
    parameter int DVF_W   = 5,
    parameter int PAR_LSB = 16,
    parameter int PSC_LSB = 4,
    parameter int DVF_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW_W/8-1:0] wr_be,
    input  logic [CW_W-1:0]   wr_data,
    output logic [CW_W-1:0]   rd_data,
    output logic [PAR_W-1:0]  par,
    output logic [PSC_W-1:0]  psc,
    output logic [DVF_W-1:0]  dvf,
    output logic              cfg_tgl
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PAR_LANE = PAR_LSB / 8;
    localparam int PSC_LANE = PSC_LSB / 8;
    localparam int DVF_LANE = DVF_LSB / 8;
    localparam int PAR_TOP  = PAR_LSB + PAR_W;
    localparam int LANE_TOP = PAR_LANE * 8 + 7;

    logic par_bad;
    logic par_wr;
    logic psc_wr;
    logic dvf_wr;

    // Any set bit above the parent field inside its lane means index >= 4.
    always_comb begin
        par_bad = |wr_data[LANE_TOP:PAR_TOP];
        par_wr  = wr_en && wr_be[PAR_LANE] && !par_bad;
        psc_wr  = wr_en && wr_be[PSC_LANE];
        dvf_wr  = wr_en && wr_be[DVF_LANE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par     <= '0;
            psc     <= '0;
            dvf     <= '0;
            cfg_tgl <= 1'b0;
        end else begin
            if (par_wr) par <= wr_data[PAR_LSB +: PAR_W];
            if (psc_wr) psc <= wr_data[PSC_LSB +: PSC_W];
            if (dvf_wr) dvf <= wr_data[DVF_LSB +: DVF_W];
            if (wr_en)  cfg_tgl <= ~cfg_tgl;
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[PAR_LSB +: PAR_W]    = par;
        rd_data[PSC_LSB +: PSC_W]    = psc;
        rd_data[DVF_LSB +: DVF_W]    = dvf;
    end

    // R6
    par_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[PAR_LANE] && par_bad) |=> (par == $past(par)));

    // R5
    dvf_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[DVF_LANE]) |=> $stable(dvf));

    // R5
    psc_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[PSC_LANE]) |=> $stable(psc));
endmodule

// File: rtl/prediv_clkmux.sv
module prediv_clkmux #(
    parameter int NUM_REF = 4,
    parameter int PAR_W   = 2
) (
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_clk,
    input  logic [PAR_W-1:0]   par,
    output logic               mclk
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NUM_REF-1:0] en_q;
    logic [NUM_REF-1:0] gated;

    for (genvar gi = 0; gi < NUM_REF; gi++) begin : g_lane
        logic want;
        logic arm;
        logic en;

        // Request this lane only once every other lane has let go.
        always_comb
            want = (par == PAR_W'(gi)) &&
                   ((en_q & ~(NUM_REF'(1) << gi)) == '0);

        always_ff @(posedge ref_clk[gi] or negedge rst_n) begin
            if (!rst_n) arm <= 1'b0;
            else        arm <= want;
        end

        // Enable changes while the reference is low, so no partial pulse.
        always_ff @(negedge ref_clk[gi] or negedge rst_n) begin
            if (!rst_n) en <= 1'b0;
            else        en <= arm;
        end

        assign en_q[gi]  = en;
        assign gated[gi] = ref_clk[gi] & en;
    end

    assign mclk = |gated;

    // R10
    one_lane_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $onehot0(en_q));
endmodule

// File: rtl/prediv_cfgsync.sv
module prediv_cfgsync #(
    parameter int PSC_W = 2,
    parameter int DVF_W = 5
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             cfg_tgl,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [DVF_W-1:0] dvf_in,
    output logic [PSC_W-1:0] psc_pend,
    output logic [DVF_W-1:0] dvf_pend
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0] tg_q;
    logic       seen;

    always_comb seen = tg_q[2] ^ tg_q[1];

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q     <= '0;
            psc_pend <= '0;
            dvf_pend <= '0;
        end else begin
            tg_q <= {tg_q[1:0], cfg_tgl};
            if (seen) begin
                psc_pend <= psc_in;
                dvf_pend <= dvf_in;
            end
        end
    end
endmodule

// File: rtl/prediv_divcore.sv
module prediv_divcore
    import prediv_pkg::*;
#(
    parameter int PSC_W = 2,
    parameter int DVF_W = 5
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_pend,
    input  logic [DVF_W-1:0] dvf_pend,
    output logic             clk_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SH_W  = (2 ** PSC_W) - 1;
    localparam int POS_W = DVF_W + SH_W;
    localparam int TOT_W = POS_W + 1;

    logic [SH_W-1:0]  pre_cnt;
    logic [DVF_W-1:0] div_cnt;
    logic [PSC_W-1:0] shd_psc;
    logic [DVF_W-1:0] shd_dvf;
    logic [SH_W-1:0]  pre_lim;
    logic             pre_last;
    logic             at_end;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt_pos;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] half;
    logic             next_is_one;
    phase_e           st_q;
    phase_e           st_d;

    always_comb begin
        pre_lim     = SH_W'((32'd1 << shd_psc) - 32'd1);
        pre_last    = (pre_cnt == pre_lim);
        at_end      = pre_last && (div_cnt == shd_dvf);
        pos         = (POS_W'(div_cnt) << shd_psc) | POS_W'(pre_cnt);
        nxt_pos     = at_end ? '0 : pos + POS_W'(1);
        total       = (TOT_W'(shd_dvf) + TOT_W'(1)) << shd_psc;
        half        = total >> 1;
        next_is_one = (psc_pend == '0) && (dvf_pend == '0);
    end

    // Cascaded prescale and divide counters, settings loaded at period end.
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            shd_psc <= '0;
            shd_dvf <= '0;
        end else if (at_end) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            shd_psc <= psc_pend;
            shd_dvf <= dvf_pend;
        end else if (pre_last) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + DVF_W'(1);
        end else begin
            pre_cnt <= pre_cnt + SH_W'(1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (at_end) begin
            st_d = next_is_one ? ST_PASS : ST_HIGH;
        end else begin
            unique case (st_q)
                ST_PASS: st_d = ST_PASS;
                ST_HIGH: if (TOT_W'(nxt_pos) >= half) st_d = ST_LOW;
                ST_LOW:  st_d = ST_LOW;
                default: st_d = ST_PASS;
            endcase
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PASS;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_PASS: clk_out = mclk;
            ST_HIGH: clk_out = 1'b1;
            ST_LOW:  clk_out = 1'b0;
            default: clk_out = 1'b0;
        endcase
    end

    // R8
    high_phase_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (st_q == ST_HIGH) |-> (TOT_W'(pos) < half));

    // R8
    low_phase_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (st_q == ST_LOW) |-> (TOT_W'(pos) >= half));

    // R4
    pos_bound_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        TOT_W'(pos) < total);

    // R9
    pass_only_unity_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (st_q == ST_PASS) |-> (total == TOT_W'(1)));
endmodule

// File: rtl/prediv_clkgen.sv
module prediv_clkgen
    import prediv_pkg::*;
#(
    parameter int P_CW_W    = CW_W,
    parameter int P_NUM_REF = NUM_REF,
    parameter int P_PAR_W   = PAR_W,
    parameter int P_PSC_W   = PSC_W,
    parameter int P_DVF_W   = DVF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [P_CW_W/8-1:0]  wr_be,
    input  logic [P_CW_W-1:0]    wr_data,
    output logic [P_CW_W-1:0]    rd_data,
    input  logic [P_NUM_REF-1:0] ref_clk,
    output logic                 clk_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [P_PAR_W-1:0] par;
    logic [P_PSC_W-1:0] psc;
    logic [P_DVF_W-1:0] dvf;
    logic               cfg_tgl;
    logic               mclk;
    logic [P_PSC_W-1:0] psc_pend;
    logic [P_DVF_W-1:0] dvf_pend;

    prediv_regs #(
        .CW_W(P_CW_W), .PAR_W(P_PAR_W), .PSC_W(P_PSC_W), .DVF_W(P_DVF_W),
        .PAR_LSB(PAR_LSB), .PSC_LSB(PSC_LSB), .DVF_LSB(DVF_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .par(par), .psc(psc),
        .dvf(dvf), .cfg_tgl(cfg_tgl)
    );

    prediv_clkmux #(.NUM_REF(P_NUM_REF), .PAR_W(P_PAR_W)) u_mux (
        .rst_n(rst_n), .ref_clk(ref_clk), .par(par), .mclk(mclk)
    );

    prediv_cfgsync #(.PSC_W(P_PSC_W), .DVF_W(P_DVF_W)) u_sync (
        .mclk(mclk), .rst_n(rst_n), .cfg_tgl(cfg_tgl), .psc_in(psc),
        .dvf_in(dvf), .psc_pend(psc_pend), .dvf_pend(dvf_pend)
    );

    prediv_divcore #(.PSC_W(P_PSC_W), .DVF_W(P_DVF_W)) u_core (
        .mclk(mclk), .rst_n(rst_n), .psc_pend(psc_pend),
        .dvf_pend(dvf_pend), .clk_out(clk_out)
    );
endmodule

// File: tb/prediv_clkgen_bench.sv
module prediv_clkgen_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        r0 = 1'b0, r1 = 1'b0, r2 = 1'b0, r3 = 1'b0;
    logic [3:0]  ref_clk;
    logic        clk_out;

    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    realtime last_edge = 0;

    logic [1:0] e_sel = '0;
    logic [1:0] e_pre = '0;
    logic [4:0] e_div = '0;

    assign ref_clk = {r3, r2, r1, r0};

    always #2.5 clk = ~clk;
    always #3 r0 = ~r0;
    always #4 r1 = ~r1;
    always #5 r2 = ~r2;
    always #7 r3 = ~r3;

    prediv_clkgen u_prediv_clkgen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .ref_clk(ref_clk),
        .clk_out(clk_out)
    );

    function automatic real ref_per(input logic [1:0] s);
        case (s)
            2'd0: return 6.0;
            2'd1: return 8.0;
            2'd2: return 10.0;
            default: return 14.0;
        endcase
    endfunction

    function automatic logic [31:0] exp_word();
        return {14'b0, e_sel, 3'b0, e_div, 2'b0, e_pre, 4'b0};
    endfunction

    function automatic int exp_total();
        return (int'(e_div) + 1) << e_pre;
    endfunction

    // R9: every output pulse must be at least half the fastest reference period.
    always @(clk_out) begin
        if (mon_on) begin
            tests++;
            if ($realtime - last_edge < 2.99) begin
                fails++;
                $display("FAIL R9 pulse width actual=%0t expected>=3ns", $realtime - last_edge);
            end
        end
        last_edge = $realtime;
    end

    task automatic chk_word(input string req);
        @(negedge clk);
        tests++;
        if (rd_data !== exp_word()) begin
            fails++;
            $display("FAIL %s readback actual=%h expected=%h", req, rd_data, exp_word());
        end
    endtask

    task automatic chk_real(input string req, input string what, input real act, input real exp);
        tests++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            fails++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
        if (be[0]) e_pre = d[5:4];
        if (be[1]) e_div = d[12:8];
        if (be[2] && d[23:18] == 6'd0) e_sel = d[17:16];
    endtask

    task automatic chk_out(input string req);
        realtime t1, t2, t3;
        real tp, per_exp, hi_exp;
        int d;
        repeat (40) @(negedge clk);
        @(posedge clk_out);
        @(posedge clk_out);
        t1 = $realtime;
        @(negedge clk_out);
        t2 = $realtime;
        @(posedge clk_out);
        t3 = $realtime;
        d = exp_total();
        tp = ref_per(e_sel);
        per_exp = d * tp;
        hi_exp = (d == 1) ? tp / 2.0 : (d / 2) * tp;
        chk_real(req, "period", t3 - t1, per_exp);
        chk_real(req, "high", t2 - t1, hi_exp);
    endtask

    function automatic logic [31:0] word(input logic [1:0] s, input logic [1:0] p, input logic [4:0] n);
        return {14'b0, s, 3'b0, n, 2'b0, p, 4'b0};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset word and pass-through of reference 0 (R8 for D = 1)
        chk_word("R1");
        chk_out("R1");
        mon_on = 1'b1;

        // R2 parent lane only; R5 other fields untouched
        bus_write(4'b0100, word(2'd2, 2'd3, 5'd31));
        chk_word("R5");
        chk_out("R2");

        // R3 prescale lane only with garbage elsewhere
        bus_write(4'b0001, 32'hFFFF_FF30);
        chk_word("R5");
        chk_out("R3");

        // R4 largest division: 256 on reference 2
        bus_write(4'b0010, word(2'd0, 2'd0, 5'd31));
        chk_word("R4");
        chk_out("R4");

        // R6 rejected parent index (bit 18 set), divide lane still written
        bus_write(4'b0110, word(2'd1, 2'd0, 5'd2) | 32'h0004_0000);
        chk_word("R6");
        chk_out("R6");

        // R7 all ones except rejecting bits: unused bits stay zero
        bus_write(4'b1111, 32'hFF03_FFFF);
        chk_word("R7");
        tests++;
        if (rd_data !== 32'h0003_1F30) begin
            fails++;
            $display("FAIL R7 word actual=%h expected=%h", rd_data, 32'h0003_1F30);
        end
        chk_out("R4");

        // R8 odd total 3 and odd total 5
        bus_write(4'b0111, word(2'd1, 2'd0, 5'd2));
        chk_out("R8");
        bus_write(4'b0111, word(2'd3, 2'd0, 5'd4));
        chk_out("R8");
        // R8 even total 2 then back to pass-through on another parent
        bus_write(4'b0111, word(2'd0, 2'd1, 5'd0));
        chk_out("R8");
        bus_write(4'b0111, word(2'd1, 2'd0, 5'd0));
        chk_out("R2");

        // Random mix, checked for R2, R3, R4, R8; pulse monitor for R9 and R10
        for (int i = 0; i < 24; i++) begin
            logic [1:0] s;
            logic [1:0] p;
            logic [4:0] n;
            logic [3:0] be;
            s = 2'($urandom_range(0, 3));
            p = 2'($urandom_range(0, 3));
            n = 5'($urandom_range(0, 31));
            be = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 7)) : 4'b0111;
            bus_write(be, word(s, p, n));
            chk_word("R5");
            if (i % 3 == 0) begin
                // back-to-back write mid period before measuring (R9)
                bus_write(4'b0111, word(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31))));
            end
            chk_out("R8");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule